// File: doc/BRIEF.md
# Checkpointed Register Valid-Bit Tracker

This block holds the live valid bit of every physical register in an out-of-order core. It can roll that state back to an earlier point in a single cycle. A decoder hands it one instruction group at a time, identified by a small group index. When the group is accepted, the tracker stores a copy of the live valid vector, as it stood just before the group, in that group's history slot. It also stores the mask of registers the group will release once it retires. It then sets the valid bits of the destinations the group allocates.

Writebacks set single valid bits while groups are in flight. When a group retires, its release mask is presented once on a free-list output for one cycle. When a group is recovered after a mispredict, its saved vector is written over the live valid bits in one step. The recovered group's slot is freed, and so is the slot of every group decoded after it. The per-slot busy flags let the decoder see which group indices it may hand out next.

All updates are registered, and outputs change on the clock edge that follows the request. Groups must be decoded in ring order of their index.

Top module: `ckpt_valid_tracker`

## Requirements
- R1: After reset, valid_o is all zeros, grp_busy_o is all zeros, free_valid_o is 0 and free_mask_o is all zeros.
- R2: A decode whose slot is idle, with no effective recovery in the same cycle, makes grp_busy_o[dec_gid_i] 1 on the next cycle and ORs dec_alloc_i into valid_o.
- R3: The vector saved for a group is valid_o as it was in the decode cycle, before that cycle's allocations and writeback are applied.
- R4: A writeback sets bit wb_preg_i of valid_o on the next cycle, where wb_preg_i is a 6-bit register number and bit n of valid_o belongs to register n.
- R5: A retire of a busy slot gives free_valid_o = 1 for exactly the next cycle, with free_mask_o equal to the release mask given at that group's decode, and it frees the slot. Outside such a pulse, free_mask_o is all zeros.
- R6: A recovery of a busy slot replaces valid_o on the next cycle with the vector saved for that group.
- R7: An effective recovery takes priority over any decode and any writeback in the same cycle. Both of those are discarded.
- R8: An effective recovery frees the recovered slot and every busy slot decoded after it. Slots decoded before it stay busy.
- R9: A decode into a busy slot, a retire of an idle slot and a recovery of an idle slot each leave valid_o, grp_busy_o and the free-list output unchanged.
- R10: A retire of a slot that is freed by a recovery in the same cycle produces no free-list pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode request for a group |
| dec_gid_i | input | 2 | Group index of the decode |
| dec_alloc_i | input | 64 | Registers newly allocated by the group |
| dec_release_i | input | 64 | Registers released when the group retires |
| wb_valid_i | input | 1 | Result writeback strobe |
| wb_preg_i | input | 6 | Register number written back |
| ret_valid_i | input | 1 | Retire request |
| ret_gid_i | input | 2 | Group index to retire |
| rec_valid_i | input | 1 | Recovery request |
| rec_gid_i | input | 2 | Group index to recover |
| valid_o | output | 64 | Live register valid bits |
| grp_busy_o | output | 4 | History slot in use, one bit per group |
| free_valid_o | output | 1 | Free-list pulse |
| free_mask_o | output | 64 | Registers handed to the free list |

## Verification
Recovery can fall in the same cycle as writeback or decode, and it can also coincide with a retire of a group it squashes. The bench drives a recovery together with a writeback to a fresh register and a decode of the next group. It then judges that valid_o equals the recovered snapshot exactly, without the writeback bit, and that the decoded slot stays idle. A second case retires a group in the same cycle that an older group is recovered, and it requires that no free-list pulse follows.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  localparam int unsigned DEF_NUM_PREGS  = 64;
  localparam int unsigned DEF_NUM_GROUPS = 4;

  // ring distance from base to idx, modulo the slot count
  function automatic int unsigned ring_dist(input int unsigned idx,
                                            input int unsigned base,
                                            input int unsigned n);
    return (idx + n - base) % n;
  endfunction
endpackage

// File: rtl/ckpt_live_vec.sv
module ckpt_live_vec #(
  parameter int NUM_PREGS = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restore_i,
  input  logic [NUM_PREGS-1:0] restore_vec_i,
  input  logic [NUM_PREGS-1:0] set_vec_i,
  output logic [NUM_PREGS-1:0] live_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        live_o <= '0;
    else if (restore_i) live_o <= restore_vec_i;
    else                live_o <= live_o | set_vec_i;
  end
endmodule

// File: rtl/ckpt_slot.sv
module ckpt_slot #(
  parameter int NUM_PREGS = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 capture_i,
  input  logic [NUM_PREGS-1:0] snap_i,
  input  logic [NUM_PREGS-1:0] rel_i,
  input  logic                 kill_i,
  input  logic                 retire_i,
  output logic                 busy_o,
  output logic [NUM_PREGS-1:0] snap_o,
  output logic [NUM_PREGS-1:0] rel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      snap_o <= '0;
      rel_o  <= '0;
    end else begin
      if (capture_i) begin
        busy_o <= 1'b1;
        snap_o <= snap_i;
        rel_o  <= rel_i;
      end else if (kill_i || retire_i) begin
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ckpt_age_ctrl.sv
module ckpt_age_ctrl
  import ckpt_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int GID_W = $clog2(NUM_GROUPS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dec_ok_i,
  input  logic [GID_W-1:0]      dec_gid_i,
  input  logic                  rec_ok_i,
  input  logic [GID_W-1:0]      rec_gid_i,
  input  logic [NUM_GROUPS-1:0] busy_i,
  output logic [NUM_GROUPS-1:0] kill_o
);
  logic [GID_W-1:0] tail_q;   // index following the youngest decoded group
  int unsigned      tail_dist;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tail_q <= '0;
    else if (rec_ok_i) tail_q <= rec_gid_i;
    else if (dec_ok_i) tail_q <= GID_W'(dec_gid_i + 1'b1);
  end

  assign tail_dist = ring_dist(int'(tail_q), int'(rec_gid_i), NUM_GROUPS);

  // tail_dist == 0 with the recovered slot busy means the ring is full
  // and the recovered group is the oldest one: every slot goes.
  for (genvar j = 0; j < NUM_GROUPS; j++) begin : g_kill
    assign kill_o[j] = rec_ok_i && busy_i[j] &&
                       ((tail_dist == 0) ||
                        (ring_dist(j, int'(rec_gid_i), NUM_GROUPS) < tail_dist));
  end
endmodule

// File: rtl/ckpt_valid_tracker.sv
module ckpt_valid_tracker #(
  parameter int NUM_PREGS  = 64,
  parameter int NUM_GROUPS = 4,
  localparam int PREG_W = $clog2(NUM_PREGS),
  localparam int GID_W  = $clog2(NUM_GROUPS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dec_valid_i,
  input  logic [GID_W-1:0]      dec_gid_i,
  input  logic [NUM_PREGS-1:0]  dec_alloc_i,
  input  logic [NUM_PREGS-1:0]  dec_release_i,
  input  logic                  wb_valid_i,
  input  logic [PREG_W-1:0]     wb_preg_i,
  input  logic                  ret_valid_i,
  input  logic [GID_W-1:0]      ret_gid_i,
  input  logic                  rec_valid_i,
  input  logic [GID_W-1:0]      rec_gid_i,
  output logic [NUM_PREGS-1:0]  valid_o,
  output logic [NUM_GROUPS-1:0] grp_busy_o,
  output logic                  free_valid_o,
  output logic [NUM_PREGS-1:0]  free_mask_o
);
  logic [NUM_PREGS-1:0] snap_arr [NUM_GROUPS];
  logic [NUM_PREGS-1:0] rel_arr  [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] kill;
  logic rec_ok, dec_ok, ret_ok;
  logic [NUM_PREGS-1:0] set_vec;

  assign rec_ok = rec_valid_i && grp_busy_o[rec_gid_i];
  assign dec_ok = dec_valid_i && !grp_busy_o[dec_gid_i] && !rec_ok;
  assign ret_ok = ret_valid_i && grp_busy_o[ret_gid_i] && !kill[ret_gid_i];

  assign set_vec = (dec_ok ? dec_alloc_i : '0) |
                   (wb_valid_i ? (NUM_PREGS'(1) << wb_preg_i) : '0);

  ckpt_live_vec #(.NUM_PREGS(NUM_PREGS)) u_live (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restore_i     (rec_ok),
    .restore_vec_i (snap_arr[rec_gid_i]),
    .set_vec_i     (set_vec),
    .live_o        (valid_o)
  );

  ckpt_age_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_age (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_ok_i  (dec_ok),
    .dec_gid_i (dec_gid_i),
    .rec_ok_i  (rec_ok),
    .rec_gid_i (rec_gid_i),
    .busy_i    (grp_busy_o),
    .kill_o    (kill)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
    ckpt_slot #(.NUM_PREGS(NUM_PREGS)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (dec_ok && (dec_gid_i == GID_W'(g))),
      .snap_i    (valid_o),
      .rel_i     (dec_release_i),
      .kill_i    (kill[g]),
      .retire_i  (ret_ok && (ret_gid_i == GID_W'(g))),
      .busy_o    (grp_busy_o[g]),
      .snap_o    (snap_arr[g]),
      .rel_o     (rel_arr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_valid_o <= 1'b0;
      free_mask_o  <= '0;
    end else begin
      free_valid_o <= ret_ok;
      free_mask_o  <= ret_ok ? rel_arr[ret_gid_i] : '0;
    end
  end
endmodule

// File: rtl/ckpt_valid_tracker_chk.sv
module ckpt_valid_tracker_chk #(
  parameter int NUM_PREGS  = 64,
  parameter int NUM_GROUPS = 4,
  localparam int PREG_W = $clog2(NUM_PREGS),
  localparam int GID_W  = $clog2(NUM_GROUPS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  dec_valid_i,
  input logic [GID_W-1:0]      dec_gid_i,
  input logic [NUM_PREGS-1:0]  dec_alloc_i,
  input logic                  wb_valid_i,
  input logic [PREG_W-1:0]     wb_preg_i,
  input logic                  ret_valid_i,
  input logic [GID_W-1:0]      ret_gid_i,
  input logic                  rec_valid_i,
  input logic [GID_W-1:0]      rec_gid_i,
  input logic [NUM_PREGS-1:0]  valid_o,
  input logic [NUM_GROUPS-1:0] grp_busy_o,
  input logic                  free_valid_o,
  input logic [NUM_PREGS-1:0]  free_mask_o
);
  a_r2_dec_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i && !grp_busy_o[dec_gid_i] && !(rec_valid_i && grp_busy_o[rec_gid_i])
    |=> grp_busy_o[$past(dec_gid_i)] && ((valid_o & $past(dec_alloc_i)) == $past(dec_alloc_i)));

  a_r4_wb_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i && !(rec_valid_i && grp_busy_o[rec_gid_i]) |=> valid_o[$past(wb_preg_i)]);

  a_r5_ret_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && grp_busy_o[ret_gid_i] && !rec_valid_i |=> free_valid_o);

  a_r5_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_valid_o |-> $past(ret_valid_i));

  a_r5_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !free_valid_o |-> free_mask_o == '0);

  a_r8_rec_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && grp_busy_o[rec_gid_i] |=> !grp_busy_o[$past(rec_gid_i)]);

  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i && !ret_valid_i && !rec_valid_i |=> $stable(grp_busy_o));
endmodule

bind ckpt_valid_tracker ckpt_valid_tracker_chk #(
  .NUM_PREGS (NUM_PREGS),
  .NUM_GROUPS(NUM_GROUPS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dec_valid_i  (dec_valid_i),
  .dec_gid_i    (dec_gid_i),
  .dec_alloc_i  (dec_alloc_i),
  .wb_valid_i   (wb_valid_i),
  .wb_preg_i    (wb_preg_i),
  .ret_valid_i  (ret_valid_i),
  .ret_gid_i    (ret_gid_i),
  .rec_valid_i  (rec_valid_i),
  .rec_gid_i    (rec_gid_i),
  .valid_o      (valid_o),
  .grp_busy_o   (grp_busy_o),
  .free_valid_o (free_valid_o),
  .free_mask_o  (free_mask_o)
);

// File: tb/sim_ckpt_valid_tracker.sv
module sim_ckpt_valid_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_gid = '0;
  logic [63:0] dec_alloc = '0;
  logic [63:0] dec_release = '0;
  logic        wb_valid = 1'b0;
  logic [5:0]  wb_preg = '0;
  logic        ret_valid = 1'b0;
  logic [1:0]  ret_gid = '0;
  logic        rec_valid = 1'b0;
  logic [1:0]  rec_gid = '0;
  logic [63:0] valid;
  logic [3:0]  grp_busy;
  logic        free_valid;
  logic [63:0] free_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model, built from the requirements
  logic [63:0] m_live = '0;
  logic [63:0] m_snap [4];
  logic [63:0] m_rel  [4];
  bit          m_busy [4];
  int          m_seq  [4];
  int          seq_ctr = 0;
  bit          m_fv = 1'b0;
  logic [63:0] m_fm = '0;

  always #2 clk = ~clk;

  ckpt_valid_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_valid_i(dec_valid), .dec_gid_i(dec_gid),
    .dec_alloc_i(dec_alloc), .dec_release_i(dec_release),
    .wb_valid_i(wb_valid), .wb_preg_i(wb_preg),
    .ret_valid_i(ret_valid), .ret_gid_i(ret_gid),
    .rec_valid_i(rec_valid), .rec_gid_i(rec_gid),
    .valid_o(valid), .grp_busy_o(grp_busy),
    .free_valid_o(free_valid), .free_mask_o(free_mask)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [3:0] eb;
    for (int j = 0; j < 4; j++) eb[j] = m_busy[j];
    chk(tag, "valid_o", valid, m_live);
    chk(tag, "grp_busy_o", 64'(grp_busy), 64'(eb));
    chk(tag, "free_valid_o", 64'(free_valid), 64'(m_fv));
    chk(tag, "free_mask_o", free_mask, m_fm);
  endtask

  // one clock: drive, update model, compare after the edge
  task automatic cyc(input bit dv, input int dg, input logic [63:0] da, input logic [63:0] dr,
                     input bit wv, input int wp, input bit tv, input int tg,
                     input bit rv, input int rg, input string tag);
    bit rec_ok, dec_ok, ret_ok;
    bit kill [4];
    logic [63:0] nlive;
    @(negedge clk);
    dec_valid = dv; dec_gid = 2'(dg); dec_alloc = da; dec_release = dr;
    wb_valid = wv; wb_preg = 6'(wp);
    ret_valid = tv; ret_gid = 2'(tg);
    rec_valid = rv; rec_gid = 2'(rg);
    rec_ok = rv && m_busy[rg];
    for (int j = 0; j < 4; j++)
      kill[j] = rec_ok && m_busy[j] && (m_seq[j] >= m_seq[rg]);
    dec_ok = dv && !m_busy[dg] && !rec_ok;
    ret_ok = tv && m_busy[tg] && !kill[tg];
    if (rec_ok) nlive = m_snap[rg];
    else nlive = m_live | (dec_ok ? da : 64'h0) | (wv ? (64'h1 << wp) : 64'h0);
    m_fv = ret_ok;
    m_fm = ret_ok ? m_rel[tg] : 64'h0;
    for (int j = 0; j < 4; j++) if (kill[j]) m_busy[j] = 1'b0;
    if (ret_ok) m_busy[tg] = 1'b0;
    if (dec_ok) begin
      m_snap[dg] = m_live; m_rel[dg] = dr; m_busy[dg] = 1'b1;
      m_seq[dg] = seq_ctr; seq_ctr++;
    end
    m_live = nlive;
    @(posedge clk);
    #1;
    dec_valid = 1'b0; wb_valid = 1'b0; ret_valid = 1'b0; rec_valid = 1'b0;
    chk_all(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, '0, '0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic t_reset;
    for (int j = 0; j < 4; j++) begin m_busy[j] = 0; m_snap[j] = '0; m_rel[j] = '0; m_seq[j] = 0; end
    #1;
    chk_all("R1");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk_all("R1");
    idle("R1");
  endtask

  task automatic t_decode_wb;
    cyc(1, 0, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_000F, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, '0, '0, 1, 10, 0, 0, 0, 0, "R4");
    cyc(0, 0, '0, '0, 1, 63, 0, 0, 0, 0, "R4");
  endtask

  task automatic t_retire;
    cyc(0, 0, '0, '0, 0, 0, 1, 0, 0, 0, "R5");
    chk("R5", "pulse seen", 64'(free_valid), 64'h1);
    idle("R5");
    chk("R5", "pulse ended", 64'(free_valid), 64'h0);
  endtask

  task automatic t_recover;
    cyc(1, 1, 64'h0000_0000_0000_0F00, 64'h0000_0000_0000_0010, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 2, 64'h0000_0000_000F_0000, 64'h0000_0000_0000_0100, 1, 50, 0, 0, 0, 0, "R3");
    cyc(1, 3, 64'h0000_0000_0F00_0000, 64'h0000_0000_0000_1000, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, '0, '0, 0, 0, 0, 0, 1, 2, "R6");
    chk("R8", "older group kept", 64'(grp_busy), 64'h2);
    chk("R3", "same-cycle writeback not in snapshot", 64'(valid[50]), 64'h0);
  endtask

  task automatic t_same_cycle;
    cyc(1, 2, 64'h00F0_0000_0000_0000, 64'h0000_0000_0001_0000, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 3, 64'h0F00_0000_0000_0000, 64'h0000_0000_0002_0000, 1, 40, 0, 0, 1, 2, "R7");
    chk("R7", "writeback discarded", 64'(valid[40]), 64'h0);
    chk("R7", "decode discarded", 64'(grp_busy[3]), 64'h0);
  endtask

  task automatic t_ignored;
    cyc(1, 1, 64'hF000_0000_0000_0000, 64'h0000_0000_0000_0001, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, '0, '0, 0, 0, 1, 0, 0, 0, "R9");
    cyc(0, 0, '0, '0, 1, 33, 0, 0, 1, 3, "R9");
  endtask

  task automatic t_retire_kill;
    cyc(1, 2, 64'h0000_00F0_0000_0000, 64'h0000_0000_0004_0000, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, '0, '0, 0, 0, 1, 2, 1, 1, "R10");
    chk("R10", "no pulse", 64'(free_valid), 64'h0);
    chk("R8", "all slots freed", 64'(grp_busy), 64'h0);
    idle("R10");
  endtask

  task automatic t_ring_full;
    cyc(1, 1, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0020, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 2, 64'h0000_0000_0000_0004, 64'h0000_0000_0000_0040, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 3, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_0080, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0800, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, '0, '0, 0, 0, 1, 1, 0, 0, "R5");
    cyc(0, 0, '0, '0, 0, 0, 0, 0, 1, 3, "R8");
    chk("R8", "oldest busy kept", 64'(grp_busy), 64'h4);
  endtask

  initial begin
    t_reset();
    t_decode_wb();
    t_retire();
    t_recover();
    t_same_cycle();
    t_ignored();
    t_retire_kill();
    t_ring_full();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule